// File: doc/BRIEF.md
# Beat width adapter

This block joins two valid/ready streams whose payloads have different widths. When the output is wider than the input, it collects several consecutive input beats into one output beat. When the output is narrower, it hands out one input beat as a sequence of output beats. The parameters set the two widths, the slice order (first beat in the least or the most significant slice), and whether widths that are not whole multiples of each other are accepted.

Both sides follow the usual valid/ready rules. A transfer happens only in a cycle where valid and ready are both high. Once a source raises valid, it keeps valid high and the payload unchanged until that transfer happens. Ready may change at any time.

In pack mode the block holds exactly one packed beat. While that beat waits for the sink, the input is held off.

In split mode the block has no payload storage. It keeps the input beat waiting until its last slice has been accepted, so the upstream source holds the word stable for the whole split.

With equal widths, the block is a plain wire-through. A configuration with mismatched widths and padding off stops elaboration with an error.

Top module: `beat_width_adapter`

## Requirements
- R1: In pack mode (OUT_W > IN_W), out_valid rises only after exactly S = ceil(OUT_W/IN_W) input transfers. Idle cycles with in_valid low between beats do not count. The slice counter returns to slice 0 after the S-th beat, so the next group starts fresh.
- R2: In pack mode with lower-first order (ORDER = ORDER_LOW_FIRST, value 0), the k-th accepted beat of a group (k from 0) appears at out_data[k*IN_W +: IN_W].
- R3: With higher-first order (ORDER = ORDER_HIGH_FIRST, value 1), beat or slice k uses slot S-1-k, in both modes. Slot j is bits [j*W +: W] of the padded word, where W is the narrower width.
- R4: In pack mode, in_ready is low while a packed beat is pending. Offered input is not absorbed during that time, and out_valid and out_data stay unchanged until out_ready. In the cycle after the output transfer, out_valid is low and in_ready is high.
- R5: In split mode (OUT_W < IN_W) with lower-first order, the k-th output beat for an input word is in_data[k*OUT_W +: OUT_W]. The first slice after the last one of a word is slice 0 of the next word.
- R6: In split mode, out_valid follows in_valid in the same cycle. in_ready is high only when the final slice is being offered and out_ready is high. The input transfer therefore coincides with the last output transfer.
- R7: In split mode, while out_ready is low the current slice stays on out_data, the slice position does not advance, and in_ready stays low.
- R8: With PAD_EN = 1 and widths that are not multiples, the narrower width W defines a padded word of S*W bits. In split mode the input is zero-extended to this width, so the bits above IN_W come out as zeros. In pack mode the output is the low OUT_W bits of the packed word, and higher bits are dropped.
- R9: After reset, a packer shows out_valid low and in_ready high. A splitter starts at slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | IN_W | Input payload |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | OUT_W | Output payload |

## Verification
On every cycle, the assertions check the following:
- The number of input transfers behind each packed beat.
- That a packed beat and a stalled slice hold still under back-pressure.
- The release of the input once a packed beat leaves.
- That a split word is accepted only together with its final slice, after exactly S-1 earlier slices.
- Where the first beat of a group lands in the packed output.

Only the directed scenarios show the following:
- The full bit layout of each output beat in both orders.
- The zero fill and truncation of the padded configurations.
- That a beat offered during a stall is not absorbed.
- The starting slice after reset.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } slice_order_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Slot that beat number idx occupies; the mapping is its own inverse.
  function automatic int slot_of(input int idx, input int count, input slice_order_e ord);
    return (ord == ORDER_LOW_FIRST) ? idx : (count - 1 - idx);
  endfunction

endpackage

// File: rtl/bwa_slice_ctr.sv
module bwa_slice_ctr #(
  parameter int COUNT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  output logic [$clog2(COUNT)-1:0]   idx,
  output logic                       at_last
);
  localparam int CW = $clog2(COUNT);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= at_last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/bwa_packer.sv
module bwa_packer #(
  parameter int                    IN_W  = 8,
  parameter int                    OUT_W = 32,
  parameter bwa_pkg::slice_order_e ORDER = bwa_pkg::ORDER_LOW_FIRST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  import bwa_pkg::*;

  localparam int NSLICE = ceil_div(OUT_W, IN_W);
  localparam int CW     = $clog2(NSLICE);
  localparam int BUF_W  = NSLICE * IN_W;

  logic [BUF_W-1:0] acc_q;
  logic             full_q;
  logic [CW-1:0]    idx;
  logic             at_last;
  logic             take;

  assign in_ready  = !full_q;
  assign take      = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = acc_q[OUT_W-1:0];

  bwa_slice_ctr #(.COUNT(NSLICE)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (take),
    .idx     (idx),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (take) begin
      for (int s = 0; s < NSLICE; s++) begin
        if (idx == CW'(slot_of(s, NSLICE, ORDER))) acc_q[s*IN_W +: IN_W] <= in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      full_q <= 1'b0;
    else if (take && at_last)        full_q <= 1'b1;
    else if (out_valid && out_ready) full_q <= 1'b0;
  end
endmodule

// File: rtl/bwa_splitter.sv
module bwa_splitter #(
  parameter int                    IN_W  = 32,
  parameter int                    OUT_W = 8,
  parameter bwa_pkg::slice_order_e ORDER = bwa_pkg::ORDER_LOW_FIRST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  import bwa_pkg::*;

  localparam int NSLICE = ceil_div(IN_W, OUT_W);
  localparam int CW     = $clog2(NSLICE);
  localparam int PAD_W  = NSLICE * OUT_W;

  logic [PAD_W-1:0] wide;
  logic [CW-1:0]    idx;
  logic             at_last;
  logic             give;

  assign wide      = PAD_W'(in_data);
  assign out_valid = in_valid;
  assign give      = out_valid && out_ready;
  assign in_ready  = out_ready && at_last;

  bwa_slice_ctr #(.COUNT(NSLICE)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (give),
    .idx     (idx),
    .at_last (at_last)
  );

  always_comb begin
    out_data = '0;
    for (int s = 0; s < NSLICE; s++) begin
      if (idx == CW'(slot_of(s, NSLICE, ORDER))) out_data = wide[s*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/beat_width_adapter.sv
module beat_width_adapter #(
  parameter int                    IN_W   = 8,
  parameter int                    OUT_W  = 32,
  parameter bwa_pkg::slice_order_e ORDER  = bwa_pkg::ORDER_LOW_FIRST,
  parameter bit                    PAD_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam bit WIDE_OUT = (OUT_W > IN_W);
  localparam bit EVEN     = WIDE_OUT ? ((OUT_W % IN_W) == 0) : ((IN_W % OUT_W) == 0);

  if (!EVEN && !PAD_EN) begin : g_reject
    $error("beat_width_adapter: widths are not multiples and padding is off");
  end

  if (WIDE_OUT) begin : g_pack
    bwa_packer #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
    );
  end else if (OUT_W < IN_W) begin : g_split
    bwa_splitter #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
    );
  end else begin : g_wire
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int                    IN_W  = 8,
  parameter int                    OUT_W = 32,
  parameter bwa_pkg::slice_order_e ORDER = bwa_pkg::ORDER_LOW_FIRST
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  import bwa_pkg::*;

  if (OUT_W > IN_W) begin : g_pack
    localparam int NSLICE = ceil_div(OUT_W, IN_W);
    localparam int TOP_W  = OUT_W - (NSLICE - 1) * IN_W;
    logic [15:0]     n_in;
    logic [IN_W-1:0] first_beat;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      n_in <= '0;
      else if (in_valid && in_ready)   n_in <= n_in + 16'd1;
      else if (out_valid && out_ready) n_in <= '0;
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready && n_in == 16'd0) first_beat <= in_data;
    end

    assert_pack_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> n_in == 16'(NSLICE));

    assert_no_overrun_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> n_in < 16'(NSLICE));

    assert_pack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_pack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid && in_ready));

    if (ORDER == ORDER_LOW_FIRST) begin : g_lo
      assert_first_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_data[IN_W-1:0] == first_beat);
    end else begin : g_hi
      assert_first_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_data[OUT_W-1 -: TOP_W] == first_beat[TOP_W-1:0]);
    end
  end else if (OUT_W < IN_W) begin : g_split
    localparam int NSLICE = ceil_div(IN_W, OUT_W);
    logic [15:0] n_out;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      n_out <= '0;
      else if (in_valid && in_ready)   n_out <= '0;
      else if (out_valid && out_ready) n_out <= n_out + 16'd1;
    end

    assert_split_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (out_valid && out_ready && n_out == 16'(NSLICE - 1)));

    assert_split_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (!in_valid || !$stable(in_data) || $stable(out_data)));
  end
endmodule

bind beat_width_adapter bwa_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) i_bwa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_beat_width_adapter.sv
module test_beat_width_adapter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // A: pack 8->32 lower-first
  logic a_iv = 0, a_ir, a_ov, a_or = 0;
  logic [7:0] a_id = '0;
  logic [31:0] a_od;
  // B: pack 8->20 higher-first, padded
  logic b_iv = 0, b_ir, b_ov, b_or = 0;
  logic [7:0] b_id = '0;
  logic [19:0] b_od;
  // C: split 32->8 lower-first
  logic c_iv = 0, c_ir, c_ov, c_or = 0;
  logic [31:0] c_id = '0;
  logic [7:0] c_od;
  // D: split 20->8 higher-first, padded
  logic d_iv = 0, d_ir, d_ov, d_or = 0;
  logic [19:0] d_id = '0;
  logic [7:0] d_od;

  beat_width_adapter i_beat_width_adapter (
    .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id),
    .out_valid(a_ov), .out_ready(a_or), .out_data(a_od));

  beat_width_adapter #(.IN_W(8), .OUT_W(20), .ORDER(bwa_pkg::ORDER_HIGH_FIRST), .PAD_EN(1'b1))
    i_beat_width_adapter_pk_hi (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir), .in_data(b_id),
    .out_valid(b_ov), .out_ready(b_or), .out_data(b_od));

  beat_width_adapter #(.IN_W(32), .OUT_W(8)) i_beat_width_adapter_sp_lo (
    .clk(clk), .rst_n(rst_n), .in_valid(c_iv), .in_ready(c_ir), .in_data(c_id),
    .out_valid(c_ov), .out_ready(c_or), .out_data(c_od));

  beat_width_adapter #(.IN_W(20), .OUT_W(8), .ORDER(bwa_pkg::ORDER_HIGH_FIRST), .PAD_EN(1'b1))
    i_beat_width_adapter_sp_hi (
    .clk(clk), .rst_n(rst_n), .in_valid(d_iv), .in_ready(d_ir), .in_data(d_id),
    .out_valid(d_ov), .out_ready(d_or), .out_data(d_od));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R9 pack out_valid in reset", a_ov, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 pack out_valid after reset", a_ov, 0);
    chk("R9 pack in_ready after reset", a_ir, 1);
    chk("R9 padded pack in_ready after reset", b_ir, 1);
    c_iv = 1; c_id = 32'hA1B2C3D4; c_or = 0; #1;
    chk("R9 split starts at slice 0", c_od, 8'hD4);
    chk("R9 split in_ready low", c_ir, 0);
    c_iv = 0;
  endtask

  task automatic t_pack_lower();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      a_iv = 1; a_id = 8'(17 * (i + 1)); #1;
      chk("R1 in_ready open while collecting", a_ir, 1);
      chk("R1 no output before last beat", a_ov, 0);
    end
    @(negedge clk);
    a_iv = 1; a_id = 8'h55; #1;
    chk("R1 output after four beats", a_ov, 1);
    chk("R2 lower-first layout", a_od, 32'h44332211);
    chk("R4 input held off while pending", a_ir, 0);
    @(negedge clk); #1;
    chk("R4 output held under stall", a_od, 32'h44332211);
    chk("R4 out_valid held under stall", a_ov, 1);
    a_or = 1; #1;
    chk("R4 still pending before fire", a_ov, 1);
    @(negedge clk); #1;
    chk("R4 out_valid low after fire", a_ov, 0);
    chk("R4 in_ready back after fire", a_ir, 1);
    @(negedge clk); a_iv = 0;
    @(negedge clk); a_iv = 1; a_id = 8'h66;
    @(negedge clk); a_id = 8'h77; #1;
    chk("R1 gap not counted", a_ov, 0);
    @(negedge clk); a_id = 8'h88; #1;
    chk("R1 three beats not enough", a_ov, 0);
    @(negedge clk); a_iv = 0; #1;
    chk("R1 counter restarted at slice 0", a_ov, 1);
    chk("R2 second word layout", a_od, 32'h88776655);
    @(negedge clk); #1;
    chk("R4 word left", a_ov, 0);
    a_or = 0;
  endtask

  task automatic t_pack_higher_pad();
    b_or = 1;
    @(negedge clk); b_iv = 1; b_id = 8'hA5;
    @(negedge clk); b_id = 8'h3C;
    @(negedge clk); b_id = 8'h96; #1;
    chk("R1 padded pack waits for third beat", b_ov, 0);
    @(negedge clk); b_iv = 0; #1;
    chk("R1 padded pack valid", b_ov, 1);
    chk("R3 R8 higher-first truncated layout", b_od, 20'h53C96);
    @(negedge clk); #1;
    chk("R4 padded pack word left", b_ov, 0);
    b_or = 0;
  endtask

  task automatic t_split_lower();
    logic [31:0] w;
    w = 32'hA1B2C3D4;
    @(negedge clk); c_iv = 1; c_id = w; c_or = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R5 lower-first slice", c_od, 32'(w[k*8 +: 8]));
      chk("R6 out_valid follows in_valid", c_ov, 1);
      chk("R6 in_ready only on last slice", c_ir, (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    c_id = 32'h0F1E2D3C; #1;
    chk("R5 next word starts at slice 0", c_od, 8'h3C);
    @(negedge clk);
    c_or = 0; #1;
    chk("R7 slice shown under stall", c_od, 8'h2D);
    chk("R7 in_ready low under stall", c_ir, 0);
    @(negedge clk); #1;
    chk("R7 slice held after stalled cycle", c_od, 8'h2D);
    c_or = 1;
    @(negedge clk); #1;
    chk("R5 third slice", c_od, 8'h1E);
    @(negedge clk); #1;
    chk("R5 final slice", c_od, 8'h0F);
    chk("R6 in_ready with final slice", c_ir, 1);
    @(negedge clk);
    c_iv = 0; #1;
    chk("R6 out_valid drops with in_valid", c_ov, 0);
    c_or = 0;
  endtask

  task automatic t_split_higher_pad();
    @(negedge clk); d_iv = 1; d_id = 20'hABCDE; d_or = 1; #1;
    chk("R3 R8 first slice zero-filled", d_od, 8'h0A);
    chk("R6 padded split not done", d_ir, 0);
    @(negedge clk); #1;
    chk("R3 middle slice", d_od, 8'hBC);
    @(negedge clk); #1;
    chk("R3 last slice", d_od, 8'hDE);
    chk("R6 padded split accepts word", d_ir, 1);
    @(negedge clk);
    d_iv = 0; d_or = 0;
  endtask

  initial begin
    t_reset();
    t_pack_lower();
    t_pack_higher_pad();
    t_split_lower();
    t_split_higher_pad();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule